// File: doc/BRIEF.md
# Four-Channel Input Capture Unit

This block timestamps edges on four external inputs against a shared 16-bit free-running counter supplied from outside. Each channel resynchronises its input through two flops, detects an edge of the polarity chosen by its own select bit, and then does two things at the same clock edge. It loads the counter value into that channel's capture register, and it sets that channel's flag.

Software reaches the unit over a byte-wide register port. Each capture register is read as two bytes. Reading the upper byte parks the lower byte in a shared holding register, so a capture that lands between the two reads cannot tear the value. Flags clear by a read-then-write-zero handshake. The edge-select bits sit in a read/write byte.

Register addresses, for NCH = 4:
- Address `2*i` returns the upper byte of channel i.
- Address `2*i+1` returns the held lower byte.
- Address 8 holds the flags, with channel i in bit i.
- Address 9 holds the edge selects, with channel i in bit i and the unused upper bits reading 0.

Top module: `icap_quad`

## Requirements
- R1: After reset every capture register reads 0x0000, the flag byte (address 8) reads 0x00 and the edge-select byte (address 9) reads 0x00.
- R2: With select bit i = 1, a 0-to-1 change on pin_i[i] captures and sets flag i; a 1-to-0 change leaves capture register i and flag i untouched.
- R3: With select bit i = 0, a 1-to-0 change on pin_i[i] captures and sets flag i; a 0-to-1 change leaves capture register i and flag i untouched.
- R4: A pin change first sampled at clock edge k loads capture register i with the value cnt_i holds at edge k+2.
- R5: Flag i becomes 1 at the same clock edge at which capture register i is loaded.
- R6: Channels are independent: any set of simultaneous pin changes captures on exactly the channels whose change matches their own select bit, all with the same counter value.
- R7: Writing address 8 clears flag i only if wdata_i[i] is 0 and flag i was read as 1 at address 8 since the previous write to address 8. Writing 1, or writing 0 without such a read, leaves the flag set.
- R8: A capture on channel i at the same clock edge as a clearing write to address 8 leaves flag i set.
- R9: Reading the upper byte of channel i copies its lower byte into a holding register. Address 2*i+1 returns that held byte, even if the channel captured again after the upper-byte read.
- R10: The edge-select byte at address 9 is writable; bits [3:0] read back as written and bits [7:4] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Free-running counter value to timestamp with |
| pin_i | input | 4 | Asynchronous capture inputs, one per channel |
| addr_i | input | 4 | Register byte address |
| rd_i | input | 1 | Read strobe (side effects: lower-byte hold, flag arming) |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |

## Verification
The bench sweeps every non-empty set of simultaneous pin toggles under four select patterns. A design that mixed up polarity, or let one channel's edge leak into another, would show wrong flags or wrong timestamps there. Timestamps are checked against a counter that advances by an odd step each cycle, so any extra or missing synchroniser stage gives an off-by-one-step value.

A clearing write is forced onto the exact edge of a new capture, where a clear-priority design drops the flag. Separate cases write zero without a prior flag read, where an eager design would clear it. A capture is also injected between the upper-byte and lower-byte reads, where a design without the holding register returns a torn value.

// File: rtl/icap_pkg.sv
package icap_pkg;
  localparam int unsigned NCH_DEF  = 4;
  localparam int unsigned CW_DEF   = 16;
  localparam int unsigned SYNC_DEF = 2;
endpackage

// File: rtl/icap_edge_det.sv
module icap_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  // [STAGES-1:0] synchroniser, [STAGES] previous synchronised level
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  always_comb begin
    if (rise_sel_i) hit_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
    else            hit_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
  end
endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int unsigned CW   = 16,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pin_i,
  input  logic          rise_sel_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          clr_i,
  output logic [CW-1:0] cap_o,
  output logic          flag_o,
  output logic          stb_o
);
  logic [CW-1:0] cap_q;
  logic          flag_q;

  icap_edge_det #(.STAGES(SYNC)) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (pin_i),
    .rise_sel_i (rise_sel_i),
    .hit_o      (stb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (stb_o) cap_q <= cnt_i;
      // set wins over clear
      if (stb_o)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/icap_quad.sv
module icap_quad
  import icap_pkg::*;
#(
  parameter int unsigned NCH  = NCH_DEF,
  parameter int unsigned CW   = CW_DEF,
  parameter int unsigned SYNC = SYNC_DEF,
  parameter int unsigned AW   = $clog2(2*NCH+2),
  parameter int unsigned DW   = CW/2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic [NCH-1:0] pin_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam logic [AW-1:0] FLAG_ADDR = AW'(2*NCH);
  localparam logic [AW-1:0] SEL_ADDR  = AW'(2*NCH+1);

  logic [NCH-1:0]    sel_q, armed_q, flag, stb, clr;
  logic [DW-1:0]     tmp_q, lo_pick;
  logic              hi_hit;
  logic [CW-1:0]     cap [NCH];
  logic [NCH*CW-1:0] cap_flat;

  wire flag_wr = wr_i && (addr_i == FLAG_ADDR);
  wire flag_rd = rd_i && (addr_i == FLAG_ADDR);

  assign clr = flag_wr ? (armed_q & ~wdata_i[NCH-1:0]) : '0;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    icap_channel #(.CW(CW), .SYNC(SYNC)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_i[g]),
      .rise_sel_i (sel_q[g]),
      .cnt_i      (cnt_i),
      .clr_i      (clr[g]),
      .cap_o      (cap[g]),
      .flag_o     (flag[g]),
      .stb_o      (stb[g])
    );
    assign cap_flat[g*CW +: CW] = cap[g];
  end

  always_comb begin
    rdata_o = '0;
    hi_hit  = 1'b0;
    lo_pick = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == AW'(2*i)) begin
        rdata_o = cap[i][CW-1:DW];
        hi_hit  = 1'b1;
        lo_pick = cap[i][DW-1:0];
      end
      if (addr_i == AW'(2*i+1)) rdata_o = tmp_q;
    end
    if (addr_i == FLAG_ADDR) rdata_o = DW'(flag);
    if (addr_i == SEL_ADDR)  rdata_o = DW'(sel_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      armed_q <= '0;
      tmp_q   <= '0;
    end else begin
      if (wr_i && addr_i == SEL_ADDR) sel_q <= wdata_i[NCH-1:0];
      if (rd_i && hi_hit) tmp_q <= lo_pick;
      if (flag_wr)      armed_q <= '0;
      else if (flag_rd) armed_q <= armed_q | flag;
    end
  end
endmodule

// File: rtl/icap_quad_chk.sv
module icap_quad_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned CW  = 16,
  parameter int unsigned AW  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CW-1:0]     cnt_i,
  input logic [AW-1:0]     addr_i,
  input logic              wr_i,
  input logic [NCH-1:0]    stb_i,
  input logic [NCH-1:0]    flag_i,
  input logic [NCH*CW-1:0] cap_i
);
  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R5
    stb_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i[g] |=> flag_i[g]);
    // R4
    cap_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i[g] |=> cap_i[g*CW +: CW] == $past(cnt_i));
    // R2
    cap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !stb_i[g] |=> $stable(cap_i[g*CW +: CW]));
    // R5
    flag_rise_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i[g]) |-> $past(stb_i[g]));
    // R7
    flag_fall_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_i[g]) |-> $past(wr_i && addr_i == AW'(2*NCH)));
    // R8
    set_beats_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_i[g] |=> !$fell(flag_i[g]));
  end
endmodule

bind icap_quad icap_quad_chk #(.NCH(NCH), .CW(CW), .AW(AW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cnt_i  (cnt_i),
  .addr_i (addr_i),
  .wr_i   (wr_i),
  .stb_i  (stb),
  .flag_i (flag),
  .cap_i  (cap_flat)
);

// File: tb/test_icap_quad.sv
`timescale 1ns/1ps
module test_icap_quad;
  localparam logic [15:0] STEP = 16'h0b3d;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt;
  logic [3:0]  pin = '0;
  logic [3:0]  addr = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_cap [4];
  logic [3:0]  exp_flag = '0, exp_sel = '0;

  icap_quad i_icap_quad (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .pin_i(pin), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= 16'h0100;
    else        cnt <= cnt + STEP;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(posedge clk); #1 rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  // apply new pin levels, update model, wait for capture to settle
  task automatic drive_pins(input logic [3:0] nv);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      logic r, f;
      r = !pin[i] && nv[i];
      f = pin[i] && !nv[i];
      if (exp_sel[i] ? r : f) begin
        exp_cap[i]  = cnt + 16'(2*STEP);
        exp_flag[i] = 1'b1;
      end
    end
    pin = nv;
    repeat (4) @(posedge clk);
  endtask

  task automatic check_all(input string req);
    logic [7:0] hi, lo;
    for (int i = 0; i < 4; i++) begin
      bus_rd(4'(2*i), hi);
      bus_rd(4'(2*i+1), lo);
      chk(req, {hi, lo}, exp_cap[i]);
    end
    bus_rd(4'd8, hi);
    chk(req, hi, {4'b0, exp_flag});
  endtask

  task automatic clear_flags();
    logic [7:0] d;
    bus_rd(4'd8, d);
    bus_wr(4'd8, 8'h00);
    exp_flag = '0;
  endtask

  task automatic set_sel(input logic [3:0] v);
    logic [7:0] d;
    bus_wr(4'd9, {4'hf, v});
    exp_sel = v;
    bus_rd(4'd9, d);
    chk("R10", d, {4'b0, v});
  endtask

  initial begin
    logic [7:0]  d, hi, lo;
    logic [15:0] c, old;
    for (int i = 0; i < 4; i++) exp_cap[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check_all("R1");
    bus_rd(4'd9, d);
    chk("R1", d, 8'h00);

    // R2 rising select on ch0
    set_sel(4'b0001);
    c = cnt;
    drive_pins(4'b0001);
    check_all("R2");
    chk("R4", exp_cap[0], c + 16'(2*STEP));
    clear_flags();
    drive_pins(4'b0000);            // falling: ignored
    check_all("R2");

    // R3 falling select on ch1
    set_sel(4'b0000);
    drive_pins(4'b0010);            // rising: ignored
    check_all("R3");
    drive_pins(4'b0000);
    check_all("R3");
    clear_flags();

    // R6 sweep of all toggle sets under several select patterns
    for (int s = 0; s < 4; s++) begin
      logic [3:0] sp;
      sp = (s == 0) ? 4'h0 : (s == 1) ? 4'hf : (s == 2) ? 4'h5 : 4'ha;
      set_sel(sp);
      for (int m = 1; m < 16; m++) begin
        drive_pins(pin ^ 4'(m));
        check_all("R6");
        clear_flags();
      end
    end
    drive_pins(4'b0000);
    set_sel(4'b1111);
    clear_flags();

    // R7 clear handshake
    drive_pins(4'b0100);
    bus_wr(4'd8, 8'h00);            // no prior read: stays
    bus_rd(4'd8, d);
    chk("R7", d, 8'h04);
    bus_wr(4'd8, 8'hff);            // armed, writes 1: stays
    bus_rd(4'd8, d);
    chk("R7", d, 8'h04);
    bus_rd(4'd8, d);
    bus_wr(4'd8, 8'h00);            // armed, writes 0: clears
    bus_rd(4'd8, d);
    chk("R7", d, 8'h00);

    // R8 capture coincident with clearing write
    drive_pins(4'b0110);            // ch1 rising
    bus_rd(4'd8, d);                // arm ch1
    chk("R8", d, 8'h02);
    drive_pins(4'b0100);            // ch1 back low, ignored (rising sel)
    @(negedge clk);
    c = cnt;
    pin = 4'b0110;                  // sampled at edge k
    @(negedge clk);                 // after k
    @(negedge clk);                 // after k+1
    addr = 4'd8; wdata = 8'h00; wr = 1'b1;
    @(posedge clk); #1 wr = 1'b0;   // edge k+2: capture + clear
    bus_rd(4'd8, d);
    chk("R8", d, 8'h02);
    bus_rd(4'd2, hi);
    bus_rd(4'd3, lo);
    chk("R4", {hi, lo}, c + 16'(2*STEP));
    exp_cap[1] = c + 16'(2*STEP);
    exp_flag = 4'b0010;
    clear_flags();

    // R9 coherent byte read across a capture
    old = exp_cap[3];
    bus_rd(4'd6, hi);
    drive_pins(4'b1110);            // ch3 captures new value
    bus_rd(4'd7, lo);
    chk("R9", {hi, lo}, old);
    bus_rd(4'd6, hi);
    bus_rd(4'd7, lo);
    chk("R9", {hi, lo}, exp_cap[3]);
    bus_rd(4'd0, hi);               // other channel swaps the held byte
    bus_rd(4'd7, lo);
    chk("R9", lo, exp_cap[0][7:0]);

    // R10 upper bits read 0
    set_sel(4'b1010);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule